// File: doc/BRIEF.md
# Write-update snooping coherence controller

This block is the coherence logic of one private cache in a bus-based multiprocessor whose caches keep each other current by broadcasting writes instead of invalidating copies. It holds a small direct-mapped array of one-word lines. For each line it keeps a presence bit, a tag, a data word and one of three coherence states: clean-exclusive (Valid), Shared, and modified-exclusive (Dirty). The processor issues read or write requests. The controller answers hits locally. On a miss or a write to a shared line, it masters a bus read or a bus update, and it samples a wired-OR "copies exist" line that the other caches drive.

At the same time the controller watches the transactions of the other caches. When a snooped address hits a resident line, it drives the copies line. It then demotes the line to Shared, takes the broadcast value on an update, and writes the old contents to main memory if the line was Dirty. A line is never invalidated by coherence traffic. It leaves the array only when a conflicting miss of its own processor replaces it, and a Dirty victim is written back to memory before the new fill. Bus arbitration and memory timing stay outside the block: a grant input closes each transaction within one cycle. A bus update carries its data word, and memory takes that word.

Top module: `wuSnoopCache`

## Requirements
- R1: A read miss fills the line from `busFillData` in Valid when `copiesIn` is low at the grant, and in Shared when it is high. A later write hit on a line filled Valid issues no bus transaction. A later write hit on a line filled Shared issues one bus update.
- R2: A write miss issues a bus read (`busReqCmd`=0). With `copiesIn` low the line takes the processor word in Dirty, and nothing is written to memory. With `copiesIn` high the line goes Shared, and a bus update (`busReqCmd`=1) follows that carries the word to memory and to the other caches.
- R3: A write hit on a Valid or a Dirty line stores the word, leaves or makes the line Dirty, and causes no bus transaction and no memory write.
- R4: A write hit on a Shared line issues one bus update with the new word. The line stays Shared if `copiesIn` is high at the grant, and becomes Valid if it is low. The request completes in the cycle after the update grant.
- R5: A read hit returns the stored word on `cpuRdata` with `cpuDone`, causes no bus activity and does not change the line state.
- R6: A snooped read or update that hits a Shared line leaves it Shared. A snooped update (`snpCmd`=1) replaces the local word with `snpData`.
- R7: A snooped read or update that hits a resident line drives `copyOut` high in the same cycle and moves the line to Shared. If the line was Dirty, its old word is written on `memWrValid`/`memWrAddr`/`memWrData` in that same cycle. A snoop that misses drives nothing.
- R8: A miss that replaces a Dirty line of another tag first writes the old word to memory at the old address. Replacing a clean line writes nothing.
- R9: Snooped traffic never removes a line: after any snoop, a read of the same address is a hit with no bus transaction.
- R10: After reset every line is empty, `cpuReady` is high, and `busReqValid`, `cpuDone`, `copyOut` and `memWrValid` are low.
- R11: `cpuReady` is high only when the controller is idle and no snoop is present. A bus request stays asserted, with address and command unchanged, until it is granted. `cpuDone` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, taken when cpuReady is high |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | AW | Word address {tag, index} |
| cpuWdata | input | DW | Write word |
| cpuReady | output | 1 | Controller can take a request this cycle |
| cpuDone | output | 1 | Request completed (one-cycle pulse) |
| cpuRdata | output | DW | Read result, valid with cpuDone on reads |
| busReqValid | output | 1 | Bus transaction requested |
| busReqCmd | output | 1 | 0 = bus read, 1 = bus update |
| busReqAddr | output | AW | Transaction address |
| busReqData | output | DW | Update word |
| busGrant | input | 1 | Transaction performed this cycle |
| busFillData | input | DW | Fill word for a granted bus read |
| copiesIn | input | 1 | Wired-OR copies-exist line, sampled at grant |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 1 | Snooped command, 0 = read, 1 = update |
| snpAddr | input | AW | Snooped address |
| snpData | input | DW | Snooped update word |
| copyOut | output | 1 | This cache holds the snooped address |
| memWrValid | output | 1 | Memory write (flush or eviction) |
| memWrAddr | output | AW | Memory write address |
| memWrData | output | DW | Memory write word |

## Verification
The assertions check the handshake rules on every cycle. A pending bus request stays still until granted, an idle controller requests nothing, and done lasts one cycle. They also check that a snoop-time memory write only comes from a snoop hit, and that an update grant, or a read grant with no copies, completes the request on the next cycle. The hidden line states can only be seen through bus behaviour, so the bench scenarios carry the rest. A golden model of three caches and memory predicts, for each operation, how many bus reads, bus updates and memory writes it causes and what a read returns. That covers the fills chosen by copies-exist, the silent write upgrades, the Shared-to-Valid drop, flushes from Dirty, propagation of update data, and Dirty eviction.

// File: rtl/wuSnoopPkg.sv
package wuSnoopPkg;

  typedef enum logic [1:0] {
    LN_VALID  = 2'd0,
    LN_SHARED = 2'd1,
    LN_DIRTY  = 2'd2
  } lineState_t;

  typedef enum logic [2:0] {
    C_IDLE,
    C_CHECK,
    C_EVICT,
    C_FETCH,
    C_UPDATE
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;       // latch processor request
    logic       reqWr;         // write line at request index
    logic       reqUseFill;    // line word from bus fill instead of cpu word
    lineState_t reqState;      // state written with reqWr
    logic       snpWr;         // demote snooped line to Shared
    logic       snpTakeData;   // take snooped update word
    logic       rdataLoad;     // load read result register
    logic       rdataFromFill; // read result from bus fill
  } dpStrobe_t;

endpackage

// File: rtl/wuSnoopData.sv
module wuSnoopData
  import wuSnoopPkg::*;
#(
  parameter int AW = 6,
  parameter int IW = 2,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic            cpuWrite,
  input  logic [AW-1:0]   cpuAddr,
  input  logic [DW-1:0]   cpuWdata,
  input  logic [AW-1:0]   snpAddr,
  input  logic [DW-1:0]   snpData,
  input  logic [DW-1:0]   busFillData,
  output logic            reqIsWrite,
  output logic [AW-1:0]   reqAddr,
  output logic [DW-1:0]   reqWdata,
  output logic            reqHit,
  output lineState_t      reqLineState,
  output logic            victimDirty,
  output logic [AW-1:0]   victimAddr,
  output logic [DW-1:0]   victimData,
  output logic            snpHit,
  output lineState_t      snpLineState,
  output logic [DW-1:0]   snpLineData,
  output logic [DW-1:0]   rdata
);
  localparam int SETS = 1 << IW;
  localparam int TW   = AW - IW;

  logic             present [SETS];
  logic [TW-1:0]    tagArr  [SETS];
  lineState_t       stArr   [SETS];
  logic [DW-1:0]    dataArr [SETS];

  logic             reqWriteR;
  logic [AW-1:0]    reqAddrR;
  logic [DW-1:0]    reqWdataR;
  logic [DW-1:0]    rdataR;

  logic [IW-1:0]    reqIdx;
  logic [TW-1:0]    reqTag;
  logic [IW-1:0]    snpIdx;
  logic [TW-1:0]    snpTag;

  assign reqIdx = reqAddrR[IW-1:0];
  assign reqTag = reqAddrR[AW-1:IW];
  assign snpIdx = snpAddr[IW-1:0];
  assign snpTag = snpAddr[AW-1:IW];

  assign reqIsWrite   = reqWriteR;
  assign reqAddr      = reqAddrR;
  assign reqWdata     = reqWdataR;
  assign reqHit       = present[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign reqLineState = stArr[reqIdx];
  assign victimDirty  = present[reqIdx] && (tagArr[reqIdx] != reqTag)
                        && (stArr[reqIdx] == LN_DIRTY);
  assign victimAddr   = {tagArr[reqIdx], reqIdx};
  assign victimData   = dataArr[reqIdx];
  assign snpHit       = present[snpIdx] && (tagArr[snpIdx] == snpTag);
  assign snpLineState = stArr[snpIdx];
  assign snpLineData  = dataArr[snpIdx];
  assign rdata        = rdataR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SETS; i++) begin
        present[i] <= 1'b0;
        tagArr[i]  <= '0;
        stArr[i]   <= LN_VALID;
        dataArr[i] <= '0;
      end
      reqWriteR <= 1'b0;
      reqAddrR  <= '0;
      reqWdataR <= '0;
      rdataR    <= '0;
    end else begin
      if (strobe.capture) begin
        reqWriteR <= cpuWrite;
        reqAddrR  <= cpuAddr;
        reqWdataR <= cpuWdata;
      end
      if (strobe.snpWr) begin
        stArr[snpIdx] <= LN_SHARED;
        if (strobe.snpTakeData) dataArr[snpIdx] <= snpData;
      end
      if (strobe.reqWr) begin
        present[reqIdx] <= 1'b1;
        tagArr[reqIdx]  <= reqTag;
        stArr[reqIdx]   <= strobe.reqState;
        dataArr[reqIdx] <= strobe.reqUseFill ? busFillData : reqWdataR;
      end
      if (strobe.rdataLoad)
        rdataR <= strobe.rdataFromFill ? busFillData : dataArr[reqIdx];
    end
  end

endmodule

// File: rtl/wuSnoopCtrl.sv
module wuSnoopCtrl
  import wuSnoopPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       snpValid,
  input  logic       snpCmd,
  input  logic       busGrant,
  input  logic       copiesIn,
  input  logic       reqIsWrite,
  input  logic       reqHit,
  input  lineState_t reqLineState,
  input  logic       victimDirty,
  input  logic       snpHit,
  input  lineState_t snpLineState,
  output dpStrobe_t  strobe,
  output logic       cpuReady,
  output logic       cpuDone,
  output logic       busReqValid,
  output logic       busReqCmd,
  output logic       copyOut,
  output logic       memWrValid,
  output logic       memWrFromSnoop
);
  ctlState_t state, stateNext;
  logic      doneR, doneNext;
  logic      snpAct, flush;

  assign snpAct         = snpValid && snpHit;
  assign flush          = snpAct && (snpLineState == LN_DIRTY);
  assign copyOut        = snpAct;
  assign memWrFromSnoop = flush;
  assign memWrValid     = flush || ((state == C_EVICT) && !snpValid);
  assign cpuReady       = (state == C_IDLE) && !snpValid;
  assign busReqValid    = (state == C_FETCH) || (state == C_UPDATE);
  assign busReqCmd      = (state == C_UPDATE);
  assign cpuDone        = doneR;

  always_comb begin
    strobe             = '0;
    stateNext          = state;
    doneNext           = 1'b0;
    strobe.snpWr       = snpAct;
    strobe.snpTakeData = snpAct && snpCmd;
    unique case (state)
      C_IDLE: begin
        if (cpuReq && cpuReady) begin
          strobe.capture = 1'b1;
          stateNext      = C_CHECK;
        end
      end
      C_CHECK: begin
        if (!snpValid) begin
          if (reqHit) begin
            if (!reqIsWrite) begin
              strobe.rdataLoad = 1'b1;
              doneNext         = 1'b1;
              stateNext        = C_IDLE;
            end else if (reqLineState == LN_SHARED) begin
              stateNext = C_UPDATE;
            end else begin
              strobe.reqWr    = 1'b1;
              strobe.reqState = LN_DIRTY;
              doneNext        = 1'b1;
              stateNext       = C_IDLE;
            end
          end else begin
            stateNext = victimDirty ? C_EVICT : C_FETCH;
          end
        end
      end
      C_EVICT: begin
        if (!snpValid) stateNext = C_FETCH;
      end
      C_FETCH: begin
        if (busGrant) begin
          strobe.reqWr = 1'b1;
          if (reqIsWrite) begin
            strobe.reqState = copiesIn ? LN_SHARED : LN_DIRTY;
            if (copiesIn) begin
              stateNext = C_UPDATE;
            end else begin
              doneNext  = 1'b1;
              stateNext = C_IDLE;
            end
          end else begin
            strobe.reqUseFill    = 1'b1;
            strobe.reqState      = copiesIn ? LN_SHARED : LN_VALID;
            strobe.rdataLoad     = 1'b1;
            strobe.rdataFromFill = 1'b1;
            doneNext             = 1'b1;
            stateNext            = C_IDLE;
          end
        end
      end
      C_UPDATE: begin
        if (busGrant) begin
          strobe.reqWr    = 1'b1;
          strobe.reqState = copiesIn ? LN_SHARED : LN_VALID;
          doneNext        = 1'b1;
          stateNext       = C_IDLE;
        end
      end
      default: stateNext = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= C_IDLE;
      doneR <= 1'b0;
    end else begin
      state <= stateNext;
      doneR <= doneNext;
    end
  end

endmodule

// File: rtl/wuSnoopCache.sv
module wuSnoopCache
  import wuSnoopPkg::*;
#(
  parameter int AW = 6,
  parameter int IW = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWrite,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuReady,
  output logic          cpuDone,
  output logic [DW-1:0] cpuRdata,
  output logic          busReqValid,
  output logic          busReqCmd,
  output logic [AW-1:0] busReqAddr,
  output logic [DW-1:0] busReqData,
  input  logic          busGrant,
  input  logic [DW-1:0] busFillData,
  input  logic          copiesIn,
  input  logic          snpValid,
  input  logic          snpCmd,
  input  logic [AW-1:0] snpAddr,
  input  logic [DW-1:0] snpData,
  output logic          copyOut,
  output logic          memWrValid,
  output logic [AW-1:0] memWrAddr,
  output logic [DW-1:0] memWrData
);
  dpStrobe_t     strobe;
  logic          reqIsWrite, reqHit, victimDirty, snpHit, memWrFromSnoop;
  lineState_t    reqLineState, snpLineState;
  logic [AW-1:0] victimAddr;
  logic [DW-1:0] victimData, snpLineData;

  wuSnoopData #(.AW(AW), .IW(IW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .snpAddr(snpAddr), .snpData(snpData), .busFillData(busFillData),
    .reqIsWrite(reqIsWrite), .reqAddr(busReqAddr), .reqWdata(busReqData),
    .reqHit(reqHit), .reqLineState(reqLineState), .victimDirty(victimDirty),
    .victimAddr(victimAddr), .victimData(victimData),
    .snpHit(snpHit), .snpLineState(snpLineState), .snpLineData(snpLineData),
    .rdata(cpuRdata)
  );

  wuSnoopCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .snpValid(snpValid),
    .snpCmd(snpCmd), .busGrant(busGrant), .copiesIn(copiesIn),
    .reqIsWrite(reqIsWrite), .reqHit(reqHit), .reqLineState(reqLineState),
    .victimDirty(victimDirty), .snpHit(snpHit), .snpLineState(snpLineState),
    .strobe(strobe), .cpuReady(cpuReady), .cpuDone(cpuDone),
    .busReqValid(busReqValid), .busReqCmd(busReqCmd), .copyOut(copyOut),
    .memWrValid(memWrValid), .memWrFromSnoop(memWrFromSnoop)
  );

  assign memWrAddr = memWrFromSnoop ? snpAddr : victimAddr;
  assign memWrData = memWrFromSnoop ? snpLineData : victimData;

endmodule

// File: rtl/wuSnoopCacheChk.sv
module wuSnoopCacheChk #(
  parameter int AW = 6,
  parameter int IW = 2,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReq,
  input logic          cpuWrite,
  input logic [AW-1:0] cpuAddr,
  input logic [DW-1:0] cpuWdata,
  input logic          cpuReady,
  input logic          cpuDone,
  input logic [DW-1:0] cpuRdata,
  input logic          busReqValid,
  input logic          busReqCmd,
  input logic [AW-1:0] busReqAddr,
  input logic [DW-1:0] busReqData,
  input logic          busGrant,
  input logic [DW-1:0] busFillData,
  input logic          copiesIn,
  input logic          snpValid,
  input logic          snpCmd,
  input logic [AW-1:0] snpAddr,
  input logic [DW-1:0] snpData,
  input logic          copyOut,
  input logic          memWrValid,
  input logic [AW-1:0] memWrAddr,
  input logic [DW-1:0] memWrData
);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid && !busGrant |=> busReqValid && $stable(busReqAddr) && $stable(busReqCmd));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !busReqValid);

  assert_update_finishes_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid && busGrant && busReqCmd |=> cpuDone);

  assert_lone_fill_finishes_R1: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid && busGrant && !busReqCmd && !copiesIn |=> cpuDone);

  assert_flush_needs_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && snpValid && (memWrAddr == snpAddr) |-> copyOut);

endmodule

bind wuSnoopCache wuSnoopCacheChk #(.AW(AW), .IW(IW), .DW(DW)) uChk (.*);

// File: tb/sim_wuSnoopCache.sv
`timescale 1ns/1ps
module sim_wuSnoopCache;
  localparam int AW = 6, IW = 2, DW = 16, NC = 3, SETS = 4, MEMW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          reqA [NC], wrA [NC], readyA [NC], doneA [NC];
  logic [AW-1:0] addrA [NC];
  logic [DW-1:0] wdA [NC], rdA [NC];
  logic          bReqV [NC], bCmd [NC], gntA [NC], snpVA [NC], copyA [NC], mwV [NC];
  logic [AW-1:0] bAddr [NC], mwA [NC];
  logic [DW-1:0] bData [NC], mwD [NC];
  logic          anyGnt, copiesAll, gCmd;
  logic [1:0]    gSel;
  logic [AW-1:0] gAddr;
  logic [DW-1:0] gData, fillData;
  logic [DW-1:0] mem [MEMW];

  wuSnoopCache #(.AW(AW), .IW(IW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(reqA[0]), .cpuWrite(wrA[0]), .cpuAddr(addrA[0]),
    .cpuWdata(wdA[0]), .cpuReady(readyA[0]), .cpuDone(doneA[0]), .cpuRdata(rdA[0]),
    .busReqValid(bReqV[0]), .busReqCmd(bCmd[0]), .busReqAddr(bAddr[0]), .busReqData(bData[0]),
    .busGrant(gntA[0]), .busFillData(fillData), .copiesIn(copiesAll), .snpValid(snpVA[0]),
    .snpCmd(gCmd), .snpAddr(gAddr), .snpData(gData), .copyOut(copyA[0]),
    .memWrValid(mwV[0]), .memWrAddr(mwA[0]), .memWrData(mwD[0]));
  wuSnoopCache #(.AW(AW), .IW(IW), .DW(DW)) u1 (
    .clk(clk), .rstN(rstN), .cpuReq(reqA[1]), .cpuWrite(wrA[1]), .cpuAddr(addrA[1]),
    .cpuWdata(wdA[1]), .cpuReady(readyA[1]), .cpuDone(doneA[1]), .cpuRdata(rdA[1]),
    .busReqValid(bReqV[1]), .busReqCmd(bCmd[1]), .busReqAddr(bAddr[1]), .busReqData(bData[1]),
    .busGrant(gntA[1]), .busFillData(fillData), .copiesIn(copiesAll), .snpValid(snpVA[1]),
    .snpCmd(gCmd), .snpAddr(gAddr), .snpData(gData), .copyOut(copyA[1]),
    .memWrValid(mwV[1]), .memWrAddr(mwA[1]), .memWrData(mwD[1]));
  wuSnoopCache #(.AW(AW), .IW(IW), .DW(DW)) u2 (
    .clk(clk), .rstN(rstN), .cpuReq(reqA[2]), .cpuWrite(wrA[2]), .cpuAddr(addrA[2]),
    .cpuWdata(wdA[2]), .cpuReady(readyA[2]), .cpuDone(doneA[2]), .cpuRdata(rdA[2]),
    .busReqValid(bReqV[2]), .busReqCmd(bCmd[2]), .busReqAddr(bAddr[2]), .busReqData(bData[2]),
    .busGrant(gntA[2]), .busFillData(fillData), .copiesIn(copiesAll), .snpValid(snpVA[2]),
    .snpCmd(gCmd), .snpAddr(gAddr), .snpData(gData), .copyOut(copyA[2]),
    .memWrValid(mwV[2]), .memWrAddr(mwA[2]), .memWrData(mwD[2]));

  // shared bus: fixed priority grant, wired-OR copies line, memory
  always_comb begin
    anyGnt = bReqV[0] | bReqV[1] | bReqV[2];
    gSel   = bReqV[0] ? 2'd0 : (bReqV[1] ? 2'd1 : 2'd2);
    gAddr  = bAddr[gSel];
    gCmd   = bCmd[gSel];
    gData  = bData[gSel];
    copiesAll = 1'b0;
    fillData  = mem[gAddr];
    for (int k = 0; k < NC; k++) begin
      gntA[k]  = anyGnt && (gSel == 2'(k));
      snpVA[k] = anyGnt && (gSel != 2'(k));
      if (gSel != 2'(k)) copiesAll = copiesAll | copyA[k];
      if (mwV[k] && mwA[k] == gAddr) fillData = mwD[k];
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEMW; i++) mem[i] <= 16'hA000 + DW'(i);
    end else begin
      for (int k = 0; k < NC; k++) if (mwV[k]) mem[mwA[k]] <= mwD[k];
      if (anyGnt && gCmd) mem[gAddr] <= gData;
    end
  end

  // bookkeeping
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // golden model
  bit         gPres [NC][SETS];
  int         gTag  [NC][SETS];
  int         gSt   [NC][SETS];   // 0 Valid, 1 Shared, 2 Dirty
  logic [DW-1:0] gLine [NC][SETS];
  logic [DW-1:0] gMem [MEMW];
  int eRd, eUpd, eMem;

  int qCache[$], qRead[$], qRdV[$], qUpdV[$], qMemV[$];
  logic [DW-1:0] qData[$];
  string qTag[$];

  task automatic modelUpdate(int c, int a, logic [DW-1:0] d, output bit cp);
    int idx = a % SETS, t = a / SETS;
    cp = 0;
    eUpd++;
    for (int k = 0; k < NC; k++) begin
      if (k != c && gPres[k][idx] && gTag[k][idx] == t) begin
        cp = 1;
        if (gSt[k][idx] == 2) begin gMem[a] = gLine[k][idx]; eMem++; end
        gSt[k][idx] = 1;
        gLine[k][idx] = d;
      end
    end
    gMem[a] = d;
  endtask

  task automatic runOp(int c, bit w, int a, logic [DW-1:0] d, string rq);
    int idx = a % SETS, t = a / SETS;
    bit cp;
    logic [DW-1:0] eData = '0;
    eRd = 0; eUpd = 0; eMem = 0;
    if (gPres[c][idx] && gTag[c][idx] == t) begin
      if (!w) eData = gLine[c][idx];
      else if (gSt[c][idx] != 1) begin gSt[c][idx] = 2; gLine[c][idx] = d; end
      else begin
        modelUpdate(c, a, d, cp);
        gSt[c][idx] = cp ? 1 : 0;
        gLine[c][idx] = d;
      end
    end else begin
      if (gPres[c][idx] && gSt[c][idx] == 2) begin
        gMem[gTag[c][idx] * SETS + idx] = gLine[c][idx];
        eMem++;
      end
      eRd++;
      cp = 0;
      for (int k = 0; k < NC; k++) begin
        if (k != c && gPres[k][idx] && gTag[k][idx] == t) begin
          cp = 1;
          if (gSt[k][idx] == 2) begin gMem[a] = gLine[k][idx]; eMem++; end
          gSt[k][idx] = 1;
        end
      end
      gPres[c][idx] = 1;
      gTag[c][idx] = t;
      if (!w) begin
        gSt[c][idx] = cp ? 1 : 0;
        gLine[c][idx] = gMem[a];
        eData = gMem[a];
      end else if (!cp) begin
        gSt[c][idx] = 2;
        gLine[c][idx] = d;
      end else begin
        gLine[c][idx] = d;
        modelUpdate(c, a, d, cp);
        gSt[c][idx] = cp ? 1 : 0;
      end
    end
    qCache.push_back(c); qRead.push_back(w ? 0 : 1); qData.push_back(eData);
    qRdV.push_back(eRd); qUpdV.push_back(eUpd); qMemV.push_back(eMem); qTag.push_back(rq);
    // drive
    @(negedge clk);
    while (!readyA[c]) @(negedge clk);
    reqA[c] = 1'b1; wrA[c] = w; addrA[c] = AW'(a); wdA[c] = d;
    @(negedge clk);
    reqA[c] = 1'b0;
    while (!doneA[c]) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: counts bus activity, compares on completion
  int cntRd = 0, cntUpd = 0, cntMem = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (anyGnt && !gCmd) cntRd++;
      if (anyGnt && gCmd) cntUpd++;
      for (int k = 0; k < NC; k++) if (mwV[k]) cntMem++;
      for (int k = 0; k < NC; k++) begin
        if (doneA[k]) begin
          if (qCache.size() == 0) check(0, "R11", "unexpected done", k, -1);
          else begin
            int ec, er, x1, x2, x3;
            logic [DW-1:0] ed;
            string rq;
            ec = qCache.pop_front(); er = qRead.pop_front(); ed = qData.pop_front();
            x1 = qRdV.pop_front(); x2 = qUpdV.pop_front(); x3 = qMemV.pop_front();
            rq = qTag.pop_front();
            check(ec == k, rq, "done cache", k, ec);
            if (er != 0) check(rdA[k] == ed, rq, "read data", int'(rdA[k]), int'(ed));
            check(cntRd == x1, rq, "bus reads", cntRd, x1);
            check(cntUpd == x2, rq, "bus updates", cntUpd, x2);
            check(cntMem == x3, rq, "memory writes", cntMem, x3);
          end
          cntRd = 0; cntUpd = 0; cntMem = 0;
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < NC; k++) begin
      reqA[k] = 0; wrA[k] = 0; addrA[k] = '0; wdA[k] = '0;
      for (int s = 0; s < SETS; s++) begin
        gPres[k][s] = 0; gTag[k][s] = 0; gSt[k][s] = 0; gLine[k][s] = '0;
      end
    end
    for (int i = 0; i < MEMW; i++) gMem[i] = 16'hA000 + DW'(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NC; k++) begin
      check(readyA[k] && !bReqV[k] && !doneA[k] && !copyA[k] && !mwV[k],
            "R10", "reset outputs", {readyA[k], bReqV[k], doneA[k], copyA[k], mwV[k]}, 5'b10000);
    end

    runOp(0, 0, 6'h05, '0,       "R1 read miss alone");
    runOp(0, 1, 6'h05, 16'h1111, "R3 write hit Valid");
    runOp(0, 1, 6'h05, 16'h2222, "R3 write hit Dirty");
    runOp(1, 0, 6'h05, '0,       "R7 snoop read flushes Dirty");
    runOp(0, 1, 6'h05, 16'h3333, "R4 write hit Shared with copies");
    runOp(1, 0, 6'h05, '0,       "R6 update reached copy, R5 hit");
    runOp(2, 1, 6'h09, 16'h4444, "R2 write miss alone");
    runOp(2, 0, 6'h09, '0,       "R5 read hit Dirty");
    runOp(1, 1, 6'h09, 16'h5555, "R2 write miss with copies");
    runOp(2, 0, 6'h09, '0,       "R9 line kept after snoop, R6");
    runOp(2, 1, 6'h0D, 16'h6666, "R8 clean victim silent");
    runOp(2, 1, 6'h11, 16'h7777, "R8 Dirty victim written back");
    runOp(0, 0, 6'h0D, '0,       "R8 written back word reaches memory");
    runOp(1, 1, 6'h09, 16'h8888, "R4 write hit Shared alone goes Valid");
    runOp(1, 1, 6'h09, 16'h9999, "R4 Valid after lone update, R3");
    runOp(2, 0, 6'h0D, '0,       "R7 snoop read demotes Valid");
    runOp(0, 1, 6'h0D, 16'hAAAA, "R1 R7 demoted line updates");
    runOp(2, 0, 6'h0D, '0,       "R6 snooped update overwrote");
    runOp(1, 1, 6'h0D, 16'hBBBB, "R2 R8 write miss with copies after evict");
    runOp(0, 0, 6'h0D, '0,       "R9 R6 copy still present");
    runOp(1, 0, 6'h21, '0,       "R1 read miss with no copies");

    begin
      int bad = 0, firstA = -1;
      for (int i = 0; i < MEMW; i++) if (mem[i] !== gMem[i]) begin bad++; if (firstA < 0) firstA = i; end
      check(bad == 0, "R2 R8", "memory image", firstA < 0 ? 0 : int'(mem[firstA]),
            firstA < 0 ? 0 : int'(gMem[firstA]));
    end
    check(qCache.size() == 0, "R11", "pending operations", qCache.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R11 watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule